// File: doc/BRIEF.md
# Light-Load Burst Gating Controller

This block decides when a primary-side switching converter may fire its power switch at very light load. It watches a digital code that stands for the compensation (error-amplifier) level. When that code drops below an entry level, which sits one hysteresis band under the burst threshold, the block withdraws the switching enable and requests a low-power state.

While idle, the block does not compare the code continuously. A wake timer runs for a fixed number of clock cycles. When it expires, the block re-enables switching for a short probe window so that one pulse can refresh the output sample. At the end of the probe, the block checks the code once. If the code is strictly above the burst threshold, normal switching resumes. Otherwise the block starts another full idle period. The turn-on logic downstream ANDs its own trigger with the enable. Because each probe pulse uses the low peak current set by the entry level, a lighter load stretches the effective switching period.

Top module: `burst_gate_ctrl`

## Requirements
- R1: After reset, `sw_en` is 1, `lowpwr_req` is 0 and `burst_mode` is 0, and the block is in normal switching.
- R2: In normal switching, if `ctrl_code` is strictly below `BURST_THR - BURST_HYST` at a clock edge, then from that edge `sw_en` is 0, `lowpwr_req` is 1 and `burst_mode` is 1 (idle).
- R3: In normal switching, any `ctrl_code` at or above `BURST_THR - BURST_HYST` leaves all outputs unchanged, including codes inside the hysteresis band.
- R4: The idle state lasts exactly `WAKE_CYC` clock cycles. It is followed by a probe state of exactly `PROBE_CYC` cycles, during which `sw_en` is 1, `lowpwr_req` is 0 and `burst_mode` is 1.
- R5: During idle, the value of `ctrl_code` has no effect. Even a code far above the threshold does not shorten the idle period or end burst operation.
- R6: The exit decision is taken only at the edge that ends a probe. If `ctrl_code` is strictly greater than `BURST_THR`, normal switching resumes (outputs 1/0/0). If it is equal or lower, the block returns to idle (0/1/1).
- R7: Each return from probe to idle starts a fresh idle period of the full `WAKE_CYC` cycles.
- R8: `burst_mode` stays 1 continuously from entry until the exit of R6, across every idle and probe state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_code | input | CODE_W | Digital code of the compensation level |
| sw_en | output | 1 | Switching enable to the turn-on logic |
| lowpwr_req | output | 1 | Low-power request while idle |
| burst_mode | output | 1 | 1 while in burst operation (idle or probe) |

## Verification
The bench builds the block with an 8-bit code, a threshold of 100, a band of 7, a wake period of 20 cycles and a probe of 3 cycles. These values make several full idle/probe rounds fit in a few hundred cycles. They also put the entry edge (92 versus 93) and the restart edge (100 versus 101) on exact codes. With the short wake period, the bench can count the idle and probe lengths cycle by cycle. It can also hold a high code through a whole idle period to show that only the probe end can release burst operation.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;

    typedef enum logic [1:0] {
        BG_RUN   = 2'd0,
        BG_IDLE  = 2'd1,
        BG_PROBE = 2'd2
    } bg_state_e;

endpackage

// File: rtl/burst_wake_timer.sv
module burst_wake_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expire = run && (tmr_q.cnt == (limit - 1'b1));

    always_comb begin
        tmr_d = tmr_q;
        if (!run || expire) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tmr_q.cnt < limit)); // R4

endmodule

// File: rtl/burst_level_cmp.sv
module burst_level_cmp #(
    parameter int CODE_W     = 10,
    parameter int BURST_THR  = 310,
    parameter int BURST_HYST = 20
) (
    input  logic [CODE_W-1:0] code,
    output logic              below_entry,
    output logic              above_restart
);

    localparam logic [CODE_W-1:0] ENTRY_LVL   = CODE_W'(BURST_THR - BURST_HYST);
    localparam logic [CODE_W-1:0] RESTART_LVL = CODE_W'(BURST_THR);

    assign below_entry   = (code < ENTRY_LVL);
    assign above_restart = (code > RESTART_LVL);

endmodule

// File: rtl/burst_gate_ctrl.sv
module burst_gate_ctrl
    import burst_gate_pkg::*;
#(
    parameter int CODE_W     = 10,
    parameter int BURST_THR  = 310,
    parameter int BURST_HYST = 20,
    parameter int WAKE_CYC   = 125000,
    parameter int PROBE_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ctrl_code,
    output logic              sw_en,
    output logic              lowpwr_req,
    output logic              burst_mode
);

    localparam int MAX_CYC = (WAKE_CYC > PROBE_CYC) ? WAKE_CYC : PROBE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0]     WAKE_LIM    = CW'(WAKE_CYC);
    localparam logic [CW-1:0]     PROBE_LIM   = CW'(PROBE_CYC);
    localparam logic [CODE_W-1:0] ENTRY_LVL   = CODE_W'(BURST_THR - BURST_HYST);
    localparam logic [CODE_W-1:0] RESTART_LVL = CODE_W'(BURST_THR);

    typedef struct packed {
        bg_state_e st;
        logic      sw;
        logic      lp;
        logic      bm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          below_entry;
    logic          above_restart;
    logic          tmr_run;
    logic          tmr_expire;
    logic [CW-1:0] tmr_limit;

    burst_level_cmp #(
        .CODE_W     (CODE_W),
        .BURST_THR  (BURST_THR),
        .BURST_HYST (BURST_HYST)
    ) u_cmp (
        .code          (ctrl_code),
        .below_entry   (below_entry),
        .above_restart (above_restart)
    );

    assign tmr_run   = (ctl_q.st != BG_RUN);
    assign tmr_limit = (ctl_q.st == BG_PROBE) ? PROBE_LIM : WAKE_LIM;

    burst_wake_timer #(
        .CW (CW)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .limit  (tmr_limit),
        .expire (tmr_expire)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            BG_RUN: begin
                if (below_entry) ctl_d.st = BG_IDLE;
            end
            BG_IDLE: begin
                if (tmr_expire) ctl_d.st = BG_PROBE;
            end
            BG_PROBE: begin
                if (tmr_expire) ctl_d.st = above_restart ? BG_RUN : BG_IDLE;
            end
            default: ctl_d.st = BG_RUN;
        endcase
        ctl_d.sw = (ctl_d.st != BG_IDLE);
        ctl_d.lp = (ctl_d.st == BG_IDLE);
        ctl_d.bm = (ctl_d.st != BG_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: BG_RUN, sw: 1'b1, lp: 1'b0, bm: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sw_en      = ctl_q.sw;
    assign lowpwr_req = ctl_q.lp;
    assign burst_mode = ctl_q.bm;

    AST_ENTRY_BELOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_mode) |-> ($past(ctrl_code) < ENTRY_LVL)); // R2

    AST_EXIT_FROM_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(burst_mode) |-> ($past(ctl_q.st) == BG_PROBE)); // R5

    AST_EXIT_ABOVE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(burst_mode) |-> ($past(ctrl_code) > RESTART_LVL)); // R6

    AST_IDLE_UNTIL_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == BG_IDLE && !tmr_expire) |=> (ctl_q.st == BG_IDLE)); // R4

endmodule

// File: tb/sim_burst_gate_ctrl.sv
`timescale 1ns/1ps
module sim_burst_gate_ctrl;

    localparam int CW_T   = 8;
    localparam int THR_T  = 100;
    localparam int HYS_T  = 7;
    localparam int WAKE_T = 20;
    localparam int PRB_T  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW_T-1:0] code = 8'd150;
    logic            sw_en, lowpwr_req, burst_mode;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  sw;
        logic  lp;
        logic  bm;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #2 clk = ~clk;

    burst_gate_ctrl #(
        .CODE_W     (CW_T),
        .BURST_THR  (THR_T),
        .BURST_HYST (HYS_T),
        .WAKE_CYC   (WAKE_T),
        .PROBE_CYC  (PRB_T)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_code  (code),
        .sw_en      (sw_en),
        .lowpwr_req (lowpwr_req),
        .burst_mode (burst_mode)
    );

    task automatic push(input logic [CW_T-1:0] c, input logic sw, input logic lp,
                        input logic bm, input string tag);
        @(negedge clk);
        code = c;
        exp_q.push_back('{sw, lp, bm, tag});
    endtask

    task automatic run_n(input logic [CW_T-1:0] c, input int n, input logic sw,
                         input logic lp, input logic bm, input string tag);
        for (int i = 0; i < n; i++) push(c, sw, lp, bm, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    // monitor: compare one expected item per clock, just after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            nvec++;
            if ({sw_en, lowpwr_req, burst_mode} !== {cur.sw, cur.lp, cur.bm}) begin
                nfail++;
                $display("FAIL %s: sw/lp/bm got %b%b%b expected %b%b%b", cur.tag,
                         sw_en, lowpwr_req, burst_mode, cur.sw, cur.lp, cur.bm);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        nvec++;
        if ({sw_en, lowpwr_req, burst_mode} !== 3'b100) begin
            nfail++;
            $display("FAIL R1 reset state: got %b%b%b expected 100",
                     sw_en, lowpwr_req, burst_mode);
        end
        run_n(8'd150, 3, 1, 0, 0, "R1 normal after reset");
        run_n(8'd93, 5, 1, 0, 0, "R3 code at entry level holds normal");
        push(8'd92, 0, 1, 1, "R2 entry one below level");
        run_n(8'd150, WAKE_T - 1, 0, 1, 1, "R5 high code ignored in idle");
        run_n(8'd100, PRB_T, 1, 0, 1, "R4 probe window");
        push(8'd100, 0, 1, 1, "R6 code equal threshold back to idle");
        run_n(8'd100, WAKE_T - 1, 0, 1, 1, "R7 second full idle period");
        run_n(8'd101, PRB_T, 1, 0, 1, "R8 burst held through second probe");
        push(8'd101, 1, 0, 0, "R6 code above threshold resumes");
        run_n(8'd101, 4, 1, 0, 0, "R3 normal above band");
        push(8'd0, 0, 1, 1, "R2 entry at zero code");
        run_n(8'd0, WAKE_T - 1, 0, 1, 1, "R4 idle length at zero code");
        run_n(8'd0, PRB_T, 1, 0, 1, "R4 probe at zero code");
        push(8'd0, 0, 1, 1, "R6 low code stays in burst");
        run_n(8'd0, 2, 0, 1, 1, "R8 burst after failed probe");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule